// File: doc/BRIEF.md
# RGMII Transmit Double-Data-Rate Encoder

This block takes a byte-wide transmit stream (one data byte, an enable flag and an error flag per clock) and folds it onto a narrow double-data-rate interface. That interface is a nibble-wide data bus and a single control line. Each output moves on both edges of the transmit clock, so one clock period carries a whole byte. The lower nibble is sent while the clock is high and the upper nibble while it is low. The control line shows the enable during the high phase. During the low phase it shows enable XOR error. A clean frame therefore holds the line high for the whole frame, and an error shows up only as a low pulse in the falling phase. The transmit clock is passed through to the pin side alongside the data.

The byte and both flags are registered once on the rising edge into a single captured word. Both halves of the output are taken from that same word through per-lane rising-phase and falling-phase registers, and a per-lane multiplexer selects between them according to the clock level. Idle cycles, with enable and error both low, drive all data lines to zero. A synchronous active-high reset clears every stage.

Top module: `rgtx_ddr_encoder`

## Requirements
- R1: While the clock is high, the data bus carries bits 3:0 of the captured byte (bit 0 on txd_o[0]).
- R2: While the clock is high, the control line equals the captured transmit enable.
- R3: While the clock is low, the data bus carries bits 7:4 of the captured byte (bit 4 on txd_o[0]).
- R4: While the clock is low, the control line equals the captured enable XOR the captured error.
- R5: Inputs sampled at rising edge k appear in the high phase that follows rising edge k+1 and in the low phase right after it, and both halves come from the same input byte.
- R6: When enable and error are both low, the data bus is zero and the control line is low in both phases.
- R7: During a clean frame (enable 1, error 0) the control line is high in both phases. During an errored frame (enable 1, error 1) it is high in the high phase and low in the low phase.
- R8: While the synchronous reset is high, the data bus and the control line are low in both phases from the first rising edge in reset onward, and the first phase pair after release is also low.
- R9: The forwarded clock output follows the transmit clock level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock; inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| gm_data | input | 8 | Transmit byte |
| gm_en | input | 1 | Transmit enable |
| gm_err | input | 1 | Transmit error |
| txc_o | output | 1 | Forwarded transmit clock |
| txd_o | output | 4 | Double-data-rate data nibble |
| txctl_o | output | 1 | Double-data-rate control line |

## Verification
A byte sampled at one rising edge shows up after two registers. Its low-nibble half is valid during the high phase that follows the next rising edge. Its high-nibble half is valid during the low phase that follows, once the falling-phase hold register has loaded. The bench holds each applied input as the pending word for one cycle. It then samples 1 ns after that next rising edge and 1 ns after the following falling edge, so each sample lands in the middle of a phase and never at an edge. The reset checks use the same timing: the high phase after the first rising edge in reset and the low phase after the next falling edge must both read zero.

// File: rtl/rgtx_pkg.sv
`timescale 1ns/1ps
package rgtx_pkg;

  localparam int unsigned RGTX_BYTE_W = 8;

  // data lines are driven only while a frame or an error is signalled
  function automatic logic rgtx_keep_data(input logic en, input logic err);
    return en | err;
  endfunction

  // falling-phase control level: steady high for clean frames
  function automatic logic rgtx_fall_ctl(input logic en, input logic err);
    return en ^ err;
  endfunction

endpackage

// File: rtl/rgtx_capture.sv
`timescale 1ns/1ps
module rgtx_capture #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_en,
  input  logic              in_err,
  output logic [BYTE_W-1:0] cap_data,
  output logic              cap_en,
  output logic              cap_err
);
  import rgtx_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_data <= '0;
      cap_en   <= 1'b0;
      cap_err  <= 1'b0;
    end else begin
      cap_data <= rgtx_keep_data(in_en, in_err) ? in_data : '0;
      cap_en   <= in_en;
      cap_err  <= in_err;
    end
  end

endmodule

// File: rtl/rgtx_ctl_encode.sv
`timescale 1ns/1ps
module rgtx_ctl_encode (
  input  logic en,
  input  logic err,
  output logic ctl_rise,
  output logic ctl_fall
);
  import rgtx_pkg::*;

  always_comb begin
    ctl_rise = en;
    ctl_fall = rgtx_fall_ctl(en, err);
  end

endmodule

// File: rtl/rgtx_ddr_lane.sv
`timescale 1ns/1ps
module rgtx_ddr_lane (
  input  logic clk,
  input  logic rst,
  input  logic d_rise,
  input  logic d_fall,
  output logic rise_q,
  output logic fall_q,
  output logic q
);
  logic fall_hold;

  // both halves load on the rising edge so they stay paired
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= d_rise;
      fall_q <= d_fall;
    end
  end

  // re-time the second half so it is stable across the whole low phase
  always_ff @(negedge clk) begin
    if (rst) fall_hold <= 1'b0;
    else     fall_hold <= fall_q;
  end

  assign q = clk ? rise_q : fall_hold;

endmodule

// File: rtl/rgtx_ddr_encoder.sv
`timescale 1ns/1ps
module rgtx_ddr_encoder #(
  parameter int unsigned BYTE_W = rgtx_pkg::RGTX_BYTE_W,
  localparam int unsigned NIB_W = BYTE_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] gm_data,
  input  logic              gm_en,
  input  logic              gm_err,
  output logic              txc_o,
  output logic [NIB_W-1:0]  txd_o,
  output logic              txctl_o
);
  localparam int unsigned LANES = NIB_W + 1;
  localparam int unsigned CTL_LANE = NIB_W;

  logic [BYTE_W-1:0] cap_data;
  logic              cap_en;
  logic              cap_err;
  logic              ctl_rise;
  logic              ctl_fall;
  logic [LANES-1:0]  lane_d_rise;
  logic [LANES-1:0]  lane_d_fall;
  logic [LANES-1:0]  lane_rise_q;
  logic [LANES-1:0]  lane_fall_q;
  logic [LANES-1:0]  lane_q;

  rgtx_capture #(.BYTE_W(BYTE_W)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .in_data  (gm_data),
    .in_en    (gm_en),
    .in_err   (gm_err),
    .cap_data (cap_data),
    .cap_en   (cap_en),
    .cap_err  (cap_err)
  );

  rgtx_ctl_encode u_ctl (
    .en       (cap_en),
    .err      (cap_err),
    .ctl_rise (ctl_rise),
    .ctl_fall (ctl_fall)
  );

  generate
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      if (j < NIB_W) begin : g_data
        assign lane_d_rise[j] = cap_data[j];
        assign lane_d_fall[j] = cap_data[j + NIB_W];
      end else begin : g_ctl
        assign lane_d_rise[j] = ctl_rise;
        assign lane_d_fall[j] = ctl_fall;
      end
      rgtx_ddr_lane u_lane (
        .clk    (clk),
        .rst    (rst),
        .d_rise (lane_d_rise[j]),
        .d_fall (lane_d_fall[j]),
        .rise_q (lane_rise_q[j]),
        .fall_q (lane_fall_q[j]),
        .q      (lane_q[j])
      );
    end
  endgenerate

  assign txd_o   = lane_q[NIB_W-1:0];
  assign txctl_o = lane_q[CTL_LANE];
  assign txc_o   = clk;

  // count clean edges since reset so end-to-end checks look back only that far
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)               age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  AST_RISE_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2) |-> lane_rise_q[NIB_W-1:0] ==
      (($past(gm_en, 2) | $past(gm_err, 2)) ? $past(gm_data[NIB_W-1:0], 2) : '0)); // R1
  AST_RISE_CTL: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2) |-> lane_rise_q[CTL_LANE] == $past(gm_en, 2)); // R2
  AST_FALL_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2) |-> lane_fall_q[NIB_W-1:0] ==
      (($past(gm_en, 2) | $past(gm_err, 2)) ? $past(gm_data[BYTE_W-1:NIB_W], 2) : '0)); // R3
  AST_FALL_CTL: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2) |-> lane_fall_q[CTL_LANE] == ($past(gm_en, 2) ^ $past(gm_err, 2))); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((age_q == 2'd2) && !$past(gm_en, 2) && !$past(gm_err, 2)) |->
      (lane_rise_q == '0 && lane_fall_q == '0)); // R6
  AST_GOOD_FRAME_HIGH: assert property (@(posedge clk) disable iff (rst)
    ((age_q == 2'd2) && $past(gm_en, 2) && !$past(gm_err, 2)) |->
      (lane_rise_q[CTL_LANE] && lane_fall_q[CTL_LANE])); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (lane_rise_q == '0 && lane_fall_q == '0)); // R8

endmodule

// File: tb/sim_rgtx_ddr_encoder.sv
`timescale 1ns/1ps
module sim_rgtx_ddr_encoder;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] gm_data;
  logic       gm_en;
  logic       gm_err;
  logic       txc_o;
  logic [3:0] txd_o;
  logic       txctl_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rgtx_ddr_encoder u0 (
    .clk     (clk),
    .rst     (rst),
    .gm_data (gm_data),
    .gm_en   (gm_en),
    .gm_err  (gm_err),
    .txc_o   (txc_o),
    .txd_o   (txd_o),
    .txctl_o (txctl_o)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [7:0] d, input logic en, input logic err);
    gm_data = d;
    gm_en   = en;
    gm_err  = err;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pd;
    logic       pen;
    logic       perr;
    logic       have_prev;
    logic       keep;

    rst = 1'b1;
    drive(8'hA5, 1'b1, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset high phase", {txctl_o, txd_o}, 5'h00);
    check("R9 clock high", {4'h0, txc_o}, 5'h01);
    @(negedge clk); #1;
    check("R8 reset low phase", {txctl_o, txd_o}, 5'h00);
    check("R9 clock low", {4'h0, txc_o}, 5'h00);
    rst = 1'b0;
    drive(8'h00, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R8 first pair after release high", {txctl_o, txd_o}, 5'h00);
    @(negedge clk); #1;
    check("R8 first pair after release low", {txctl_o, txd_o}, 5'h00);

    // exhaustive sweep: every byte under every enable/error mode, mode changing each cycle
    have_prev = 1'b0;
    pd = '0; pen = 1'b0; perr = 1'b0;
    for (int i = 0; i <= 1024; i++) begin
      if (i < 1024) drive(8'(i >> 2) ^ 8'(i * 37), i[0], i[1]);
      else          drive(8'h00, 1'b0, 1'b0);
      @(posedge clk); #1;
      if (have_prev) begin
        keep = pen | perr;
        check("R1 high-phase data", {1'b0, txd_o}, {1'b0, keep ? pd[3:0] : 4'h0});
        check("R2 high-phase control", {4'h0, txctl_o}, {4'h0, pen});
        if (!pen && !perr) check("R6 idle high phase", {txctl_o, txd_o}, 5'h00);
        if (pen) check("R7 frame control high phase", {4'h0, txctl_o}, 5'h01);
      end
      @(negedge clk); #1;
      if (have_prev) begin
        keep = pen | perr;
        check("R3 low-phase data", {1'b0, txd_o}, {1'b0, keep ? pd[7:4] : 4'h0});
        check("R4 low-phase control", {4'h0, txctl_o}, {4'h0, pen ^ perr});
        if (!pen && !perr) check("R6 idle low phase", {txctl_o, txd_o}, 5'h00);
        if (pen) check("R7 frame control low phase", {4'h0, txctl_o}, {4'h0, ~perr});
      end
      pd = gm_data; pen = gm_en; perr = gm_err;
      have_prev = 1'b1;
    end

    // paired halves: a distinct byte per cycle must reassemble from one high/low pair
    pd = 8'h00;
    for (int i = 0; i < 32; i++) begin
      drive(8'(8'h3C + i * 9), 1'b1, 1'b0);
      @(posedge clk); #1;
      begin
        logic [3:0] lo_half;
        lo_half = txd_o;
        @(negedge clk); #1;
        if (i > 0) check("R5 byte reassembly", {1'b0, txd_o}, {1'b0, pd[7:4]});
        if (i > 0) check("R5 low half same byte", {1'b0, lo_half}, {1'b0, pd[3:0]});
      end
      pd = gm_data;
    end

    // reset asserted in the middle of a frame
    drive(8'hFF, 1'b1, 1'b1);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R8 mid-frame reset high", {txctl_o, txd_o}, 5'h00);
    @(negedge clk); #1;
    check("R8 mid-frame reset low", {txctl_o, txd_o}, 5'h00);
    rst = 1'b0;
    drive(8'h00, 1'b0, 1'b0);
    repeat (2) @(posedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule